// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one compare channel that sits beside a free-running up/down timer counter. On every timer-clock enable it compares the counter value with an active compare register. Equality is remembered and reported on the following timer clock: at that point a sticky match flag is set and a one-cycle event pulse is produced. The flag also drives an interrupt request, gated by an enable input.

Software never writes the active compare register directly. A bus write lands in a buffer register and marks it as pending. The timer tells the channel, through an update strobe issued at TOP or BOTTOM of its count, when a transfer is safe. Only then does the pending buffer value move into the active register. Deferring the change this way means a PWM period always uses one threshold from start to finish, so no shortened or lopsided pulse can appear. The PWM level is high while the counter is below the active threshold, and it changes only on timer-clock enables.

Top module: `tcc_chan`

## Requirements
- R1: After synchronous reset, `active_cmp` is 0, and `buf_pending`, `match_flag`, `match_evt`, `irq` and `pwm_out` are all 0.
- R2: When `tick` is 1 and `cnt` equals `active_cmp`, `match_flag` becomes 1 at the clock edge of the next cycle in which `tick` is 1, and not earlier.
- R3: `match_evt` is 1 for exactly the clock cycle that follows the edge at which a match sets the flag (R2), and is 0 in every other cycle.
- R4: `irq` equals `match_flag` AND `irq_en` in every cycle.
- R5: A cycle with `wr_en` = 1 stores `wr_data` in the buffer and sets `buf_pending` to 1. `active_cmp` does not change because of the write.
- R6: A cycle with `upd` = 1 and `buf_pending` = 1 copies the buffer into `active_cmp` and clears `buf_pending`. With `buf_pending` = 0, `upd` has no effect. `active_cmp` changes at no other time.
- R7: If `wr_en` and `upd` are both 1 in one cycle while a value is pending, the older buffered value moves to `active_cmp`. The newly written value stays in the buffer with `buf_pending` = 1, waiting for the next update.
- R8: `match_flag` stays at 1 until a cycle with `flag_clr` = 1 clears it. If a set (R2) and a clear happen at the same edge, the set wins.
- R9: At an edge with `tick` = 1, `pwm_out` takes the value (`cnt` < `active_cmp`), compared unsigned. At an edge with `tick` = 0, `pwm_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer-clock enable |
| cnt | input | W | Current counter value |
| upd | input | 1 | Update point strobe (TOP or BOTTOM) |
| wr_en | input | 1 | Bus write strobe for the buffer |
| wr_data | input | W | Bus write data for the buffer |
| flag_clr | input | 1 | Write-one-to-clear of the match flag |
| irq_en | input | 1 | Interrupt enable |
| active_cmp | output | W | Active compare value |
| buf_pending | output | 1 | Buffer holds a value not yet transferred |
| match_flag | output | 1 | Sticky match flag |
| match_evt | output | 1 | One-cycle match event |
| irq | output | 1 | Interrupt request |
| pwm_out | output | 1 | PWM output level |

## Verification
The hardest case to reach is a bus write and an update strobe in the same cycle while an older value is still pending. In that case two buffer values are live at once, and only one of them may move. A second hard case is a match flag being set at the same edge at which software clears it. The stimulus reaches both in two ways. A directed sequence pre-loads the buffer and then fires the write and the strobe together. A long randomized run drives an up/down counter with irregular enables and strobes at both ends of the count, and adds frequent writes and clears. A behavioural model compares every output on every clock.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    // Control inputs of one clock cycle, grouped.
    typedef struct packed {
        logic tick;
        logic upd;
        logic wr;
        logic clr;
    } tcc_ctl_t;

    // Match pipeline state.
    typedef struct packed {
        logic pend;
        logic flag;
        logic evt;
    } tcc_match_t;

    // A transfer needs an update point and a pending value.
    function automatic logic tcc_xfer(input logic upd, input logic pending);
        return upd & pending;
    endfunction

endpackage

// File: rtl/tcc_buffer.sv
module tcc_buffer
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tcc_ctl_t     ctl,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] active,
    output logic         pending
);
    logic [W-1:0] shadow;
    logic         xfer;

    assign xfer = tcc_xfer(ctl.upd, pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            pending <= 1'b0;
            active  <= '0;
        end else begin
            if (xfer)
                active <= shadow;
            if (ctl.wr) begin
                shadow  <= wr_data;
                pending <= 1'b1;
            end else if (xfer) begin
                pending <= 1'b0;
            end
        end
    end

    // R6: active value moves only at an update point
    assert_active_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl.upd) |-> $stable(active));

    // R5 / R6: a transfer without a concurrent write empties the buffer
    assert_pending_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.upd && pending && !ctl.wr) |=> !pending);

    // R5: a write always leaves a pending value
    assert_write_pending_R5: assert property (@(posedge clk) disable iff (rst)
        ctl.wr |=> pending);

endmodule

// File: rtl/tcc_match.sv
module tcc_match
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tcc_ctl_t     ctl,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] active,
    output tcc_match_t   st
);
    logic equal;

    assign equal = (cnt == active);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.evt <= 1'b0;
            if (ctl.tick) begin
                st.pend <= equal;
                if (st.pend) begin
                    st.evt  <= 1'b1;
                    st.flag <= 1'b1;
                end else if (ctl.clr) begin
                    st.flag <= 1'b0;
                end
            end else if (ctl.clr) begin
                st.flag <= 1'b0;
            end
        end
    end

    // R3: the event always comes with the flag
    assert_evt_flag_R3: assert property (@(posedge clk) disable iff (rst)
        st.evt |-> st.flag);

    // R2: the flag only rises at an edge that carried a timer tick
    assert_flag_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(st.flag) |-> $past(ctl.tick));

    // R8: the flag only falls after a clear request
    assert_flag_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(st.flag) |-> $past(ctl.clr));

endmodule

// File: rtl/tcc_pwm.sv
module tcc_pwm
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tcc_ctl_t     ctl,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] active,
    output logic         level
);
    always_ff @(posedge clk) begin
        if (rst)
            level <= 1'b0;
        else if (ctl.tick)
            level <= (cnt < active);
    end

    // R9: the level holds between timer ticks
    assert_pwm_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl.tick) |-> $stable(level));

endmodule

// File: rtl/tcc_chan.sv
module tcc_chan
    import tcc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         upd,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         flag_clr,
    input  logic         irq_en,
    output logic [W-1:0] active_cmp,
    output logic         buf_pending,
    output logic         match_flag,
    output logic         match_evt,
    output logic         irq,
    output logic         pwm_out
);
    tcc_ctl_t   ctl;
    tcc_match_t mst;

    assign ctl = '{tick: tick, upd: upd, wr: wr_en, clr: flag_clr};

    tcc_buffer #(.W(W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .wr_data (wr_data),
        .active  (active_cmp),
        .pending (buf_pending)
    );

    tcc_match #(.W(W)) u_match (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .cnt    (cnt),
        .active (active_cmp),
        .st     (mst)
    );

    tcc_pwm #(.W(W)) u_pwm (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .cnt    (cnt),
        .active (active_cmp),
        .level  (pwm_out)
    );

    assign match_flag = mst.flag;
    assign match_evt  = mst.evt;
    assign irq        = mst.flag & irq_en;

    // R4: no request without a set flag
    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> match_flag);

endmodule

// File: tb/tcc_chan_test.sv
module tcc_chan_test;
    localparam int W = 8;
    localparam int TOP = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         upd = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         flag_clr = 1'b0;
    logic         irq_en = 1'b0;
    logic [W-1:0] active_cmp;
    logic         buf_pending, match_flag, match_evt, irq, pwm_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference
    int  m_act = 0, m_buf = 0;
    bit  m_pend = 0, m_eqseen = 0, m_flag = 0, m_evt = 0, m_pwm = 0;

    tcc_chan #(.W(W)) uut (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .upd(upd),
        .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr), .irq_en(irq_en),
        .active_cmp(active_cmp), .buf_pending(buf_pending),
        .match_flag(match_flag), .match_evt(match_evt), .irq(irq), .pwm_out(pwm_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_act <= 0; m_buf <= 0; m_pend <= 0;
            m_eqseen <= 0; m_flag <= 0; m_evt <= 0; m_pwm <= 0;
        end else begin
            if (upd && m_pend) m_act <= m_buf;
            if (wr_en) begin
                m_buf <= int'(wr_data);
                m_pend <= 1;
            end else if (upd && m_pend) begin
                m_pend <= 0;
            end
            m_evt <= tick && m_eqseen;
            if (tick && m_eqseen) m_flag <= 1;
            else if (flag_clr) m_flag <= 0;
            if (tick) begin
                m_eqseen <= (int'(cnt) == m_act);
                m_pwm <= (int'(cnt) < m_act);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R6 active_cmp", int'(active_cmp), m_act);
        chk("R5 buf_pending", int'(buf_pending), int'(m_pend));
        chk("R2/R8 match_flag", int'(match_flag), int'(m_flag));
        chk("R3 match_evt", int'(match_evt), int'(m_evt));
        chk("R4 irq", int'(irq), int'(m_flag && irq_en));
        chk("R9 pwm_out", int'(pwm_out), int'(m_pwm));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c = 0;
        int dir = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 active_cmp", int'(active_cmp), 0);
        chk("R1 buf_pending", int'(buf_pending), 0);
        chk("R1 flags", int'({match_flag, match_evt, irq, pwm_out}), 0);

        // R7 directed: pre-load 12, then write 30 together with an update
        wr_en = 1; wr_data = 8'd12;
        @(negedge clk); compare_all();
        wr_en = 1; wr_data = 8'd30; upd = 1;
        @(negedge clk); compare_all();
        chk("R7 old value transferred", int'(active_cmp), 12);
        chk("R7 new value still pending", int'(buf_pending), 1);
        wr_en = 0; upd = 1;
        @(negedge clk); compare_all();
        chk("R7 held value transferred next", int'(active_cmp), 30);
        upd = 0;
        // R6: update with nothing pending changes nothing
        upd = 1;
        @(negedge clk); compare_all();
        chk("R6 empty update ignored", int'(active_cmp), 30);
        upd = 0;

        // R2 directed: match at cnt=30, flag appears only after the next tick
        irq_en = 1; cnt = 8'd30; tick = 1;
        @(negedge clk); compare_all();
        chk("R2 not same edge", int'(match_flag), 0);
        cnt = 8'd31; tick = 0;
        @(negedge clk); compare_all();
        chk("R2 waits for next tick", int'(match_flag), 0);
        tick = 1; flag_clr = 1;
        @(negedge clk); compare_all();
        chk("R8 set wins over clear", int'(match_flag), 1);
        tick = 0; flag_clr = 0;
        @(negedge clk); compare_all();
        chk("R3 event one cycle", int'(match_evt), 0);
        flag_clr = 1;
        @(negedge clk); compare_all();
        chk("R8 clear", int'(match_flag), 0);
        flag_clr = 0;

        // randomized up/down counter run
        for (int i = 0; i < 4000; i++) begin
            tick = (($urandom % 4) != 0);
            upd = 0;
            if (tick) begin
                c = c + dir;
                if (c >= TOP) begin c = TOP; dir = -1; upd = 1; end
                else if (c <= 0) begin c = 0; dir = 1; upd = 1; end
            end
            if (($urandom % 50) == 0) upd = 1;
            cnt = W'(c);
            wr_en = (($urandom % 10) == 0);
            wr_data = W'($urandom % (TOP + 6));
            flag_clr = (($urandom % 8) == 0);
            if (($urandom % 64) == 0) irq_en = ~irq_en;
            @(negedge clk);
            compare_all();
        end
        finish_run();
    end
endmodule